// File: doc/BRIEF.md
# Serial Receiver with Tagged Word Queue

This block turns an asynchronous serial input line into parallel words for a host. It watches the line for a start bit and confirms it at mid-bit. It then samples each following bit at the centre of its period and checks the stop bit. A shared baud generator supplies an oversampling tick, and the line format is set by the same configuration inputs the transmitter uses. A frame carries seven or eight data bits, sent least significant bit first. An optional extra bit can follow the data. The receiver captures that bit unchanged and treats it as a tag that travels with its word. It does not compute or check parity.

Each received word goes, together with its tag, into a small queue. The host can instead select a single-slot mode, which makes the queue behave as one holding register. The host sees the head of the queue, a data-available flag, a framing-error flag and an overrun flag on its outputs. A one-cycle read strobe removes the head word and clears both error flags. An interrupt request combines three status conditions, each gated by its own mask input.

Top module: `uart_rx_tagq`

## Requirements
- R1: With `os_tick` high every cycle, a frame is one low start bit, the data bits least significant first, an optional tag bit, and a high stop bit, each lasting OSR cycles. Every 8-bit value is recovered exactly.
- R2: When `cfg_short` is 1, a frame carries 7 data bits, and `rd_data[7]` of that word reads 0.
- R3: When `cfg_tag_en` is 1, the bit after the data is stored unchanged as that word's `rd_tag`. When it is 0, no extra bit is expected and `rd_tag` reads 0.
- R4: In queue mode (`cfg_fifo_off` = 0), up to DEPTH words are held and read back in arrival order.
- R5: A word that arrives while the queue is full is dropped, the stored words stay unchanged, and `overrun` goes to 1. It stays 1 until the next read strobe.
- R6: When `cfg_fifo_off` is 1, only one word is held. A second word that arrives before a read is dropped and sets `overrun`.
- R7: While nothing is stored, `rd_data` and `rd_tag` read 0, and a read strobe changes nothing.
- R8: `avail` is 1 exactly while at least one unread word is stored.
- R9: A stop bit sampled low sets `frame_err`, and the word is still stored. A read strobe clears `frame_err`.
- R10: `irq` = (`msk_avail` AND `avail`) OR (`msk_tag` AND `rd_tag`) OR (`msk_ferr` AND `frame_err`).
- R11: After reset, `avail`, `frame_err`, `overrun` and `irq` are 0, and `rd_data` and `rd_tag` are 0.
- R12: A low pulse that ends before the middle of a start bit is ignored, and no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick; OSR ticks make one bit |
| rx | input | 1 | Serial line; idles high |
| cfg_short | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_tag_en | input | 1 | 1 expects one tag bit after the data |
| cfg_fifo_off | input | 1 | 1 limits storage to a single word |
| msk_avail | input | 1 | Interrupt mask for data available |
| msk_tag | input | 1 | Interrupt mask for the head word's tag |
| msk_ferr | input | 1 | Interrupt mask for framing error |
| rd_stb | input | 1 | Read strobe: removes the head word and clears the error flags |
| rd_data | output | 8 | Data bits of the head word, or 0 when empty |
| rd_tag | output | 1 | Tag bit of the head word, or 0 when empty |
| avail | output | 1 | Unread data present |
| frame_err | output | 1 | A stop bit was sampled low |
| overrun | output | 1 | A word was dropped because storage was full |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with OSR = 8 and DEPTH = 4. The shorter bit period makes it affordable to send all 256 eight-bit values and all 128 seven-bit values with tags through the real serial path. The four-deep queue fills after four frames, so both the queue-mode and single-slot overrun cases come up early. The queue is also emptied and refilled often enough to wrap its pointers many times.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   localparam int RXQ_DATA_W = 8;

   typedef struct packed {
      logic                  tag;
      logic [RXQ_DATA_W-1:0] data;
   } rxq_word_t;

   typedef enum logic [1:0] {
      DF_IDLE  = 2'd0,
      DF_START = 2'd1,
      DF_BITS  = 2'd2,
      DF_STOP  = 2'd3
   } df_state_t;

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else if (STAGES == 1) sh <= din;
            else sh <= {sh[STAGES-2:0], din};
         end
         assign dout = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rxq_deframer.sv
module rxq_deframer
   import uart_rxq_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = RXQ_DATA_W
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      os_tick,
   input  logic      rx,
   input  logic      cfg_short,
   input  logic      cfg_tag_en,
   output logic      push,
   output rxq_word_t push_word,
   output logic      push_ferr
);

   localparam int HALF = OSR / 2;
   localparam int TW   = $clog2(OSR);
   localparam int BW   = $clog2(DATA_W + 2);

   df_state_t         state;
   logic [TW-1:0]     tick_cnt;
   logic [BW-1:0]     bit_idx;
   logic [DATA_W-1:0] data_q;
   logic              tag_q;
   logic              short_q;
   logic              tag_en_q;
   logic [BW-1:0]     n_data;
   logic [BW-1:0]     last_idx;
   logic              mid_start;
   logic              bit_end;

   always_comb begin
      n_data    = short_q ? BW'(DATA_W - 1) : BW'(DATA_W);
      last_idx  = tag_en_q ? n_data : n_data - BW'(1);
      mid_start = (tick_cnt == TW'(HALF - 1));
      bit_end   = (tick_cnt == TW'(OSR - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= DF_IDLE;
         tick_cnt  <= '0;
         bit_idx   <= '0;
         data_q    <= '0;
         tag_q     <= 1'b0;
         short_q   <= 1'b0;
         tag_en_q  <= 1'b0;
         push      <= 1'b0;
         push_word <= '0;
         push_ferr <= 1'b0;
      end else begin
         push <= 1'b0;
         if (os_tick) begin
            case (state)
               DF_IDLE: begin
                  if (!rx) begin
                     state    <= DF_START;
                     tick_cnt <= '0;
                  end
               end
               DF_START: begin
                  if (mid_start) begin
                     tick_cnt <= '0;
                     if (!rx) begin
                        state    <= DF_BITS;
                        bit_idx  <= '0;
                        data_q   <= '0;
                        tag_q    <= 1'b0;
                        short_q  <= cfg_short;
                        tag_en_q <= cfg_tag_en;
                     end else begin
                        state <= DF_IDLE;
                     end
                  end else begin
                     tick_cnt <= tick_cnt + TW'(1);
                  end
               end
               DF_BITS: begin
                  if (bit_end) begin
                     tick_cnt <= '0;
                     if (bit_idx < n_data) begin
                        for (int i = 0; i < DATA_W; i++) begin
                           if (bit_idx == BW'(i)) data_q[i] <= rx;
                        end
                     end else begin
                        tag_q <= rx;
                     end
                     if (bit_idx == last_idx) state <= DF_STOP;
                     bit_idx <= bit_idx + BW'(1);
                  end else begin
                     tick_cnt <= tick_cnt + TW'(1);
                  end
               end
               DF_STOP: begin
                  if (bit_end) begin
                     tick_cnt       <= '0;
                     push           <= 1'b1;
                     push_word.data <= data_q;
                     push_word.tag  <= tag_q;
                     push_ferr      <= !rx;
                     state          <= DF_IDLE;
                  end else begin
                     tick_cnt <= tick_cnt + TW'(1);
                  end
               end
               default: state <= DF_IDLE;
            endcase
         end
      end
   end

   p_short_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && short_q) |-> (push_word.data[DATA_W-1] == 1'b0));

   p_tag_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !tag_en_q) |-> !push_word.tag);

   p_push_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          single,
   input  logic          push,
   input  rxq_word_t     push_word,
   input  logic          pop,
   output rxq_word_t     head,
   output logic [CW-1:0] count,
   output logic          drop
);

   logic [CW-1:0] cap;
   logic          full;
   logic          do_push;
   logic          do_pop;

   always_comb begin
      cap     = single ? CW'(1) : CW'(DEPTH);
      full    = (count >= cap);
      do_push = push && !full;
      do_pop  = pop && (count != '0);
      drop    = push && full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else if (do_push && !do_pop) count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
   end

   generate
      if (DEPTH == 1) begin : g_reg
         rxq_word_t slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot <= '0;
            else if (do_push) slot <= push_word;
         end
         assign head = (count == '0) ? '0 : slot;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         rxq_word_t     mem [DEPTH];
         logic [AW-1:0] wp;
         logic [AW-1:0] rp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_push) wp <= wp + AW'(1);
               if (do_pop)  rp <= rp + AW'(1);
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= push_word;
         end
         assign head = (count == '0) ? '0 : mem[rp];
      end
   endgenerate

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   p_drop_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !pop) |=> (count == $past(count)));

   p_single_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (single && $past(single) && $past(count) <= CW'(1)) |-> (count <= CW'(1)));

endmodule

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq
   import uart_rxq_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  os_tick,
   input  logic                  rx,
   input  logic                  cfg_short,
   input  logic                  cfg_tag_en,
   input  logic                  cfg_fifo_off,
   input  logic                  msk_avail,
   input  logic                  msk_tag,
   input  logic                  msk_ferr,
   input  logic                  rd_stb,
   output logic [RXQ_DATA_W-1:0] rd_data,
   output logic                  rd_tag,
   output logic                  avail,
   output logic                  frame_err,
   output logic                  overrun,
   output logic                  irq
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   logic          rx_s;
   logic          push;
   rxq_word_t     push_word;
   logic          push_ferr;
   rxq_word_t     head;
   logic [CW-1:0] count;
   logic          drop;
   logic          pop;

   rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx),
      .dout (rx_s)
   );

   rxq_deframer #(.OSR(OSR), .DATA_W(RXQ_DATA_W)) u_deframer (
      .clk       (clk),
      .rst_n     (rst_n),
      .os_tick   (os_tick),
      .rx        (rx_s),
      .cfg_short (cfg_short),
      .cfg_tag_en(cfg_tag_en),
      .push      (push),
      .push_word (push_word),
      .push_ferr (push_ferr)
   );

   rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .single   (cfg_fifo_off),
      .push     (push),
      .push_word(push_word),
      .pop      (pop),
      .head     (head),
      .count    (count),
      .drop     (drop)
   );

   assign avail   = (count != '0);
   assign pop     = rd_stb && avail;
   assign rd_data = head.data;
   assign rd_tag  = head.tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_err <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         if (push && push_ferr) frame_err <= 1'b1;
         else if (rd_stb)       frame_err <= 1'b0;
         if (drop)              overrun <= 1'b1;
         else if (rd_stb)       overrun <= 1'b0;
      end
   end

   assign irq = (msk_avail && avail) || (msk_tag && rd_tag) || (msk_ferr && frame_err);

   p_empty_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !avail |-> (rd_data == '0 && !rd_tag));

   p_ferr_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !(push && push_ferr)) |=> !frame_err);

   p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !rd_stb) |=> overrun);

   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!msk_avail && !msk_tag && !msk_ferr) |-> !irq);

endmodule

// File: tb/uart_rx_tagq_test.sv
`timescale 1ns/1ps
module uart_rx_tagq_test;

   localparam int OSR   = 8;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx = 1'b1;
   logic       cfg_short = 1'b0;
   logic       cfg_tag_en = 1'b0;
   logic       cfg_fifo_off = 1'b0;
   logic       msk_avail = 1'b0;
   logic       msk_tag = 1'b0;
   logic       msk_ferr = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       rd_tag;
   logic       avail;
   logic       frame_err;
   logic       overrun;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_rx_tagq #(.OSR(OSR), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx(rx),
      .cfg_short(cfg_short), .cfg_tag_en(cfg_tag_en), .cfg_fifo_off(cfg_fifo_off),
      .msk_avail(msk_avail), .msk_tag(msk_tag), .msk_ferr(msk_ferr),
      .rd_stb(rd_stb), .rd_data(rd_data), .rd_tag(rd_tag), .avail(avail),
      .frame_err(frame_err), .overrun(overrun), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx = v;
      repeat (OSR) @(negedge clk);
   endtask

   // sends start, nb bits of payload (LSB first), stop, then two idle bit times
   task automatic send(input logic [9:0] payload, input int nb, input logic stopv);
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < nb; i++) hold_bit(payload[i]);
      hold_bit(stopv);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic strobe();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic read_expect(input string req, input logic [8:0] exp);
      @(negedge clk);
      chk(req, {23'd0, rd_tag, rd_data}, {23'd0, exp});
      strobe();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk("R11 avail", avail, 0);
      chk("R11 flags", {frame_err, overrun, irq}, 0);
      chk("R11 data", {rd_tag, rd_data}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 read of empty storage
      strobe();
      chk("R7 empty data", {rd_tag, rd_data}, 0);
      chk("R8 avail empty", avail, 0);

      // R1 R4 full sweep of 8-bit values, groups of DEPTH
      for (int g = 0; g < 256; g += DEPTH) begin
         for (int k = 0; k < DEPTH; k++) send(10'(g + k), 8, 1'b1);
         @(negedge clk);
         chk("R8 avail full", avail, 1);
         for (int k = 0; k < DEPTH; k++) read_expect("R1 R4 order", 9'(g + k));
         @(negedge clk);
         chk("R8 avail drained", avail, 0);
      end
      chk("R5 no overrun in sweep", overrun, 0);

      // R2 R3 seven data bits plus tag, all 128 values
      cfg_short = 1'b1;
      cfg_tag_en = 1'b1;
      for (int v = 0; v < 128; v++) begin
         logic t;
         t = v[0] ^ v[3] ^ v[6];
         send({2'b00, t, 7'(v)}, 8, 1'b1);
         read_expect("R2 R3 short tagged", {t, 1'b0, 7'(v)});
      end

      // R2 short without tag: a high bit after 7 data bits is the stop bit
      cfg_tag_en = 1'b0;
      send(10'h07F, 7, 1'b1);
      read_expect("R2 short msb", 9'h07F);

      // R3 eight bits plus tag
      cfg_short = 1'b0;
      cfg_tag_en = 1'b1;
      send(10'h1A5, 9, 1'b1);
      read_expect("R3 tag one", 9'h1A5);
      send(10'h05A, 9, 1'b1);
      read_expect("R3 tag zero", 9'h05A);
      cfg_tag_en = 1'b0;

      // R9 framing error, word kept
      send(10'h0C3, 8, 1'b0);
      @(negedge clk);
      chk("R9 ferr set", frame_err, 1);
      chk("R9 word kept", {avail, rd_tag, rd_data}, {1'b1, 9'h0C3});
      strobe();
      @(negedge clk);
      chk("R9 ferr cleared", frame_err, 0);
      chk("R9 popped", avail, 0);

      // R5 overrun in queue mode
      for (int k = 0; k < DEPTH + 1; k++) send(10'(8'h40 + k), 8, 1'b1);
      @(negedge clk);
      chk("R5 overrun set", overrun, 1);
      read_expect("R5 keep first", 9'h040);
      @(negedge clk);
      chk("R5 overrun cleared", overrun, 0);
      for (int k = 1; k < DEPTH; k++) read_expect("R5 keep rest", 9'(8'h40 + k));
      @(negedge clk);
      chk("R5 extra dropped", avail, 0);

      // R6 single-slot mode
      cfg_fifo_off = 1'b1;
      send(10'h011, 8, 1'b1);
      @(negedge clk);
      chk("R6 first held", {overrun, avail}, 2'b01);
      send(10'h022, 8, 1'b1);
      @(negedge clk);
      chk("R6 second overruns", overrun, 1);
      read_expect("R6 first data", 9'h011);
      @(negedge clk);
      chk("R6 only one slot", avail, 0);
      cfg_fifo_off = 1'b0;

      // R10 interrupt masks: word with tag and framing error, then empty
      cfg_tag_en = 1'b1;
      send(10'h155, 9, 1'b0);
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         {msk_ferr, msk_tag, msk_avail} = 3'(m);
         #1;
         chk("R10 irq loaded", irq, (m[0] & avail) | (m[1] & rd_tag) | (m[2] & frame_err));
      end
      strobe();
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         {msk_ferr, msk_tag, msk_avail} = 3'(m);
         #1;
         chk("R10 irq idle", irq, 0);
      end
      send(10'h0AA, 9, 1'b1);
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         {msk_ferr, msk_tag, msk_avail} = 3'(m);
         #1;
         chk("R10 irq untagged", irq, m[0]);
      end
      {msk_ferr, msk_tag, msk_avail} = 3'b000;
      strobe();
      cfg_tag_en = 1'b0;

      // R12 short low glitch ignored
      @(negedge clk);
      rx = 1'b0;
      repeat (OSR / 4) @(negedge clk);
      rx = 1'b1;
      repeat (OSR * 12) @(negedge clk);
      chk("R12 glitch ignored", {avail, frame_err}, 0);
      send(10'h099, 8, 1'b1);
      read_expect("R12 recovers", 9'h099);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule